// File: doc/BRIEF.md
# Outstanding-Request Watchdog Timer

This block counts the high-priority management requests that the send path has in flight, and it runs a single shared timeout for as long as any of them is outstanding. Each request launch is reported with a one-cycle enqueue pulse and each completion with a one-cycle dequeue pulse. A prescaled tick advances the timer. The interval, in ticks, is derived from the tick rate as one twentieth of a second, rounded up.

The timer starts only when the count moves from zero to one. It restarts with a full interval on every completion that leaves requests outstanding, and it stops when the last request completes. When the interval runs out while requests remain, the block emits a one-cycle cancel pulse, which asks the send path to abandon all of its work. A clear input drops the count to zero and stops the timer. Misuse is recorded in sticky flags: a completion with nothing outstanding sets one, and an enqueue at the saturated count sets the other.

All pins are plain control and status signals. There is no data stream, so the block has no valid/ready handshake.

Top module: `mgmt_watchdog`

## Requirements
- R1: After reset the count is 0. The timer is stopped, cancel is low, and both error flags are low.
- R2: An enqueue alone at count 0 sets the count to 1 and arms the timer with a full interval. If nothing else happens, cancel pulses after exactly INTERVAL ticks that follow the enqueue cycle.
- R3: An enqueue alone at a nonzero count increments the count and does not alter the timer's remaining ticks or its running state.
- R4: A dequeue alone that leaves the count nonzero reloads the timer with a full interval and sets it running, even if it had already expired.
- R5: A dequeue alone that brings the count to 0 stops the timer.
- R6: INTERVAL equals ceil(TICK_HZ/20) ticks, which is 5 for TICK_HZ=100. Cycles without a tick do not advance the timer.
- R7: On expiry with a nonzero count, cancel_o is high for exactly one cycle, the cycle after the expiring tick. The timer stops and the count is kept.
- R8: An expiry that coincides with the count reaching 0 has no effect. No cancel is raised.
- R9: An enqueue and a dequeue in the same cycle leave the count and the timer as they were.
- R10: A dequeue alone at count 0 leaves the count at 0 and sets underflow_o. underflow_o stays set until reset.
- R11: clr_i forces the count to 0 and stops the timer at the next edge. It overrides enqueue, dequeue and tick in that cycle.
- R12: An enqueue at count 2^CNT_W-1 leaves the count there and sets overflow_o. overflow_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_i | input | 1 | One-cycle pulse: a request was launched |
| deq_i | input | 1 | One-cycle pulse: a request completed |
| clr_i | input | 1 | Force the count to zero and stop the timer |
| tick_i | input | 1 | Prescaled timer tick |
| outstanding_o | output | 4 (CNT_W) | Requests in flight |
| running_o | output | 1 | Timer is armed |
| cancel_o | output | 1 | One-cycle cancel-all request |
| underflow_o | output | 1 | Sticky: dequeue seen at count 0 |
| overflow_o | output | 1 | Sticky: enqueue seen at saturated count |

## Verification
The hardest case to reach is a timer expiry that falls in the same cycle as the dequeue of the last request. That race is the only path on which a timeout could see an empty count. The vector table reaches it by arming the timer and then spending exactly INTERVAL-1 ticks. The final tick is presented together with the dequeue pulse, and the following cycles are checked for the absence of a cancel. Two other cases need deliberate stimulus. One is the reload after an expiry. The other is the enqueue at a nonzero count, which must leave the timer alone; the table spaces its ticks so that a wrongly applied reload would move the cancel pulse to a different cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Command from the count tracker to the interval timer.
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,  // keep running or stopped as it is
    TMR_LOAD = 2'd1,  // (re)start with a full interval
    TMR_HALT = 2'd2   // stop
  } tmr_cmd_e;

  // Ticks in one twentieth of a second, rounded up.
  function automatic int unsigned interval_ticks(input int unsigned tick_hz);
    return (tick_hz + 19) / 20;
  endfunction
endpackage

// File: rtl/wdt_count_track.sv
module wdt_count_track
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic             deq,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output tmr_cmd_e         cmd,
  output logic             underflow,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             only_enq, only_deq;
  logic             at_zero, at_max;
  logic [CNT_W-1:0] count_nxt;
  logic             udf_hit, ovf_hit;

  assign only_enq = enq & ~deq & ~clr;
  assign only_deq = deq & ~enq & ~clr;
  assign at_zero  = (count == '0);
  assign at_max   = (count == CNT_MAX);

  always_comb begin
    count_nxt = count;
    cmd       = TMR_HOLD;
    udf_hit   = 1'b0;
    ovf_hit   = 1'b0;
    if (clr) begin
      count_nxt = '0;
      cmd       = TMR_HALT;
    end else if (only_enq) begin
      if (at_max) begin
        ovf_hit = 1'b1;
      end else begin
        count_nxt = count + CNT_ONE;
        if (at_zero) cmd = TMR_LOAD;
      end
    end else if (only_deq) begin
      if (at_zero) begin
        udf_hit = 1'b1;
      end else begin
        count_nxt = count - CNT_ONE;
        cmd       = (count == CNT_ONE) ? TMR_HALT : TMR_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      count <= count_nxt;
      if (udf_hit) underflow <= 1'b1;
      if (ovf_hit) overflow  <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
  import wdt_pkg::*;
#(
  parameter int unsigned INTERVAL = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_cmd_e cmd,
  input  logic     tick,
  output logic     running,
  output logic     expire
);
  localparam int unsigned REM_W = (INTERVAL < 2) ? 1 : $clog2(INTERVAL + 1);
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(INTERVAL);
  localparam logic [REM_W-1:0] REM_ONE  = REM_W'(1);

  logic [REM_W-1:0] remain;

  // A load or halt in the same cycle takes precedence over the tick.
  assign expire = (cmd == TMR_HOLD) & running & tick & (remain == REM_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
    end else begin
      unique case (cmd)
        TMR_LOAD: begin
          running <= 1'b1;
          remain  <= REM_FULL;
        end
        TMR_HALT: begin
          running <= 1'b0;
          remain  <= '0;
        end
        default: begin
          if (running && tick) begin
            if (remain == REM_ONE) begin
              running <= 1'b0;
              remain  <= '0;
            end else begin
              remain <= remain - REM_ONE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mgmt_watchdog.sv
module mgmt_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_i,
  input  logic             deq_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] outstanding_o,
  output logic             running_o,
  output logic             cancel_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam int unsigned INTERVAL = interval_ticks(TICK_HZ);

  tmr_cmd_e tmr_cmd;
  logic     tmr_expire;
  logic     cancel_q;

  wdt_count_track #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq       (enq_i),
    .deq       (deq_i),
    .clr       (clr_i),
    .count     (outstanding_o),
    .cmd       (tmr_cmd),
    .underflow (underflow_o),
    .overflow  (overflow_o)
  );

  wdt_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (tmr_cmd),
    .tick    (tick_i),
    .running (running_o),
    .expire  (tmr_expire)
  );

  // An expiry with nothing outstanding is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cancel_q <= 1'b0;
    else        cancel_q <= tmr_expire & (outstanding_o != '0);
  end

  assign cancel_o = cancel_q;
endmodule

// File: rtl/mgmt_watchdog_chk.sv
module mgmt_watchdog_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_i,
  input logic             deq_i,
  input logic             clr_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] outstanding_o,
  input logic             running_o,
  input logic             cancel_o,
  input logic             underflow_o,
  input logic             overflow_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_arm_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && !deq_i && !clr_i && outstanding_o == '0) |=> (running_o && outstanding_o == 1));

  assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (outstanding_o != '0));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_i && !enq_i && !clr_i && outstanding_o > 1) |=> running_o);

  assert_cancel_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |=> !cancel_o);

  assert_cancel_needs_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> ($past(running_o) && $past(tick_i)));

  assert_pair_neutral_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && deq_i && !clr_i) |=> $stable(outstanding_o));

  assert_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_i && !enq_i && !clr_i && outstanding_o == '0) |=> (underflow_o && outstanding_o == '0));

  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (outstanding_o == '0 && !running_o));

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && !deq_i && !clr_i && outstanding_o == CMAX) |=> (overflow_o && outstanding_o == CMAX));

  assert_overflow_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
endmodule

bind mgmt_watchdog mgmt_watchdog_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_mgmt_watchdog.sv
module tb_mgmt_watchdog;
  localparam int CW    = 4;
  localparam int IVL   = (100 + 19) / 20;  // R6: expect 5 ticks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_i = 0, deq_i = 0, clr_i = 0, tick_i = 0;
  logic [CW-1:0] outstanding_o;
  logic running_o, cancel_o, underflow_o, overflow_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mgmt_watchdog #(.CNT_W(CW), .TICK_HZ(100)) dut (
    .clk(clk), .rst_n(rst_n), .enq_i(enq_i), .deq_i(deq_i), .clr_i(clr_i),
    .tick_i(tick_i), .outstanding_o(outstanding_o), .running_o(running_o),
    .cancel_o(cancel_o), .underflow_o(underflow_o), .overflow_o(overflow_o)
  );

  // Vector: [17:14] req, [13] enq, [12] deq, [11] clr, [10] tick,
  // [9:6] expected count, [5] running, [4] cancel, [3:0] spare.
  function automatic logic [17:0] v(input int r, input bit e, input bit d, input bit c,
                                    input bit t, input int n, input bit run, input bit can);
    return {4'(r), e, d, c, t, 4'(n), run, can, 4'b0};
  endfunction

  localparam int NV = 49;
  localparam logic [17:0] VEC [NV] = '{
    v(2,1,0,0,0,1,1,0),                                          // R2 arm
    v(2,0,0,0,1,1,1,0), v(2,0,0,0,1,1,1,0), v(2,0,0,0,1,1,1,0), v(2,0,0,0,1,1,1,0),
    v(7,0,0,0,1,1,0,1),                                          // R7 expiry on 5th tick
    v(7,0,0,0,0,1,0,0),                                          // R7 one cycle only
    v(5,0,1,0,0,0,0,0),                                          // R5
    v(3,1,0,0,0,1,1,0), v(3,0,0,0,1,1,1,0), v(3,0,0,0,1,1,1,0),
    v(3,1,0,0,0,2,1,0),                                          // R3 enq leaves timer
    v(3,0,0,0,1,2,1,0), v(3,0,0,0,1,2,1,0),
    v(3,0,0,0,1,2,0,1),
    v(3,0,0,0,0,2,0,0),
    v(4,0,1,0,0,1,1,0),                                          // R4 reload after expiry
    v(4,0,0,0,1,1,1,0), v(4,0,0,0,1,1,1,0), v(4,0,0,0,1,1,1,0),
    v(4,1,0,0,0,2,1,0),
    v(4,0,1,0,0,1,1,0),                                          // R4 reload mid-run
    v(4,0,0,0,1,1,1,0), v(4,0,0,0,1,1,1,0), v(4,0,0,0,1,1,1,0), v(4,0,0,0,1,1,1,0),
    v(4,0,0,0,1,1,0,1),
    v(4,0,0,0,0,1,0,0),
    v(5,0,1,0,0,0,0,0),
    v(9,1,0,0,0,1,1,0), v(9,0,0,0,1,1,1,0),
    v(9,1,1,0,0,1,1,0),                                          // R9 pair is neutral
    v(9,0,0,0,1,1,1,0), v(9,0,0,0,1,1,1,0), v(9,0,0,0,1,1,1,0),
    v(9,0,0,0,1,1,0,1),
    v(9,0,0,0,0,1,0,0),
    v(8,0,1,0,0,0,0,0),
    v(8,1,0,0,0,1,1,0),
    v(8,0,0,0,1,1,1,0), v(8,0,0,0,1,1,1,0), v(8,0,0,0,1,1,1,0), v(8,0,0,0,1,1,1,0),
    v(8,0,1,0,1,0,0,0),                                          // R8 last tick with deq to zero
    v(8,0,0,0,1,0,0,0),
    v(11,1,0,0,0,1,1,0),
    v(11,1,0,1,1,0,0,0),                                         // R11 clear wins
    v(11,0,0,0,1,0,0,0),
    v(10,0,1,0,0,0,0,0)                                          // R10 deq at zero
  };

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic step(input bit e, input bit d, input bit c, input bit t);
    enq_i = e; deq_i = d; clr_i = c; tick_i = t;
    @(posedge clk);
    @(negedge clk);
    enq_i = 0; deq_i = 0; clr_i = 0; tick_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", outstanding_o, 0);
    check("R1 running", running_o, 0);
    check("R1 cancel", cancel_o, 0);
    check("R1 flags", {underflow_o, overflow_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] w;
      string tag;
      w = VEC[i];
      step(w[13], w[12], w[11], w[10]);
      tag = $sformatf("R%0d vec%0d", w[17:14], i);
      check({tag, " count"}, outstanding_o, w[9:6]);
      check({tag, " running"}, running_o, w[5]);
      check({tag, " cancel"}, cancel_o, w[4]);
    end

    // R10 sticky underflow, count unchanged
    check("R10 underflow", underflow_o, 1);
    step(0, 0, 0, 0);
    check("R10 sticky", underflow_o, 1);
    check("R12 no overflow yet", overflow_o, 0);

    // R6: interval with sparse ticks
    begin
      int seen;
      seen = 0;
      step(1, 0, 0, 0);
      for (int k = 0; k < 20 && !cancel_o; k++) begin
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        seen++;
      end
      check("R6 ticks to cancel", seen, IVL);
      step(0, 1, 0, 0);
    end

    // R12 saturation
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 underflow cleared", underflow_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 15; k++) step(1, 0, 0, 0);
    check("R12 at max", outstanding_o, 15);
    check("R12 overflow low", overflow_o, 0);
    step(1, 0, 0, 0);
    check("R12 saturated", outstanding_o, 15);
    check("R12 overflow set", overflow_o, 1);
    step(0, 1, 0, 0);
    check("R12 overflow sticky", overflow_o, 1);
    check("R12 count after deq", outstanding_o, 14);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule